// File: doc/BRIEF.md
# Cascadable presettable synchronous counter

This block is a binary up-counter built from 4-bit slices that are chained into one wider counter on a single clock. Each slice can take a parallel preset value, can be cleared to zero by an active-low clear, and counts only when both of its enables are high. Each slice also produces a look-ahead carry that feeds the next slice.

Inside the chain, the carry of each slice drives the T enable of the slice above it. Every slice shares the P enable, the clear and the load. The result behaves as one counter of `SLICES*4` bits. A compile-time parameter chooses how the clear acts. With `ASYNC_CLR=1` the clear forces zero at once. With `ASYNC_CLR=0` it waits for the next rising clock edge.

Top module: `cnt_chain`

## Requirements
- R1: With ASYNC_CLR=1, a low `clr_n` forces `count` to all zeros immediately, without waiting for a clock edge.
- R2: With ASYNC_CLR=0, a low `clr_n` leaves `count` unchanged between edges and sets it to all zeros at the next rising edge.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `count` takes the value of `preset`. Bit 0 is the LSB. The load takes effect regardless of `en_p` and `en_t`.
- R4: When `clr_n`, `load_n`, `en_p` and `en_t` are all high at a rising edge, `count` increases by one.
- R5: When `clr_n` and `load_n` are high and either enable is low, `count` keeps its value across the edge.
- R6: An increment from all ones wraps `count` to all zeros.
- R7: `carry` is high exactly when `en_t` is high and every bit of `count` is one. `en_p` has no influence on `carry`.
- R8: A low `clr_n` wins over a simultaneous low `load_n`, so the result is all zeros.
- R9: The chain counts as one wide binary counter. When the lower slice reaches 1111 it rolls over into the upper slice, so a count of 0x0F becomes 0x10.
- R10: With `en_t` low, no slice of the chain advances, even when `en_p` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_CLR |
| load_n | input | 1 | Active-low synchronous parallel load |
| preset | input | SLICES*4 | Value loaded into the counter; bit 0 is the LSB |
| en_p | input | 1 | Count enable shared by all slices |
| en_t | input | 1 | Count and carry enable for the lowest slice |
| count | output | SLICES*4 | Counter value; bit 0 is the LSB |
| carry | output | 1 | Look-ahead carry of the top slice |

## Verification
The bench builds two copies side by side, one for each clear mode, and drives both with the same stimulus. Several controls can be active in the same cycle. The bench provokes the clear together with the load, and the load together with both count enables high. Each result is judged against the priority clear, then load, then count. The clear is also dropped between two edges. The bench then checks that only the asynchronous copy has already reached zero, and that the synchronous copy reaches zero at the following edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int SLICE_W = 4;

    typedef logic [SLICE_W-1:0] nib_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic en_p;
        logic en_t;
    } ctl_t;

    // Priority: clear, load, count, hold
    function automatic op_e pick_op(input ctl_t c);
        if (!c.clr_n)              return OP_CLEAR;
        else if (!c.load_n)        return OP_LOAD;
        else if (c.en_p && c.en_t) return OP_COUNT;
        else                       return OP_HOLD;
    endfunction

endpackage

// File: rtl/cnt_slice.sv
module cnt_slice
    import cnt_pkg::*;
#(
    parameter bit ASYNC_CLR = 1'b1
)(
    input  logic clk,
    input  ctl_t ctl,
    input  nib_t preset,
    output nib_t q,
    output logic carry
);

    nib_t nxt;
    op_e  op;

    always_comb begin
        op = pick_op(ctl);
        case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = preset;
            OP_COUNT: nxt = q + 1'b1;
            default:  nxt = q;
        endcase
    end

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge ctl.clr_n) begin
                if (!ctl.clr_n) q <= '0;
                else            q <= nxt;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                q <= nxt;
            end
        end
    endgenerate

    assign carry = ctl.en_t & (&q);

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
    import cnt_pkg::*;
#(
    parameter int  SLICES    = 2,
    parameter bit  ASYNC_CLR = 1'b1,
    localparam int CW        = SLICES * SLICE_W
)(
    input  logic          clk,
    input  logic          clr_n,
    input  logic          load_n,
    input  logic [CW-1:0] preset,
    input  logic          en_p,
    input  logic          en_t,
    output logic [CW-1:0] count,
    output logic          carry
);

    logic [SLICES:0] link;

    assign link[0] = en_t;

    generate
        for (genvar i = 0; i < SLICES; i++) begin : g_slice
            ctl_t ctl_i;
            nib_t q_i;
            always_comb begin
                ctl_i.clr_n  = clr_n;
                ctl_i.load_n = load_n;
                ctl_i.en_p   = en_p;
                ctl_i.en_t   = link[i];
            end
            cnt_slice #(.ASYNC_CLR(ASYNC_CLR)) u_slice (
                .clk    (clk),
                .ctl    (ctl_i),
                .preset (preset[i*SLICE_W +: SLICE_W]),
                .q      (q_i),
                .carry  (link[i+1])
            );
            assign count[i*SLICE_W +: SLICE_W] = q_i;
        end
    endgenerate

    assign carry = link[SLICES];

endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
    parameter int CW        = 8,
    parameter bit ASYNC_CLR = 1'b1
)(
    input logic          clk,
    input logic          clr_n,
    input logic          load_n,
    input logic [CW-1:0] preset,
    input logic          en_p,
    input logic          en_t,
    input logic [CW-1:0] count,
    input logic          carry
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (!clr_n) armed <= 1'b1;
    end

    generate
        if (ASYNC_CLR) begin : g_a
            AST_CLR_NOW: assert property (@(posedge clk) disable iff (!armed)
                !clr_n |-> count == '0); // R1
        end else begin : g_s
            AST_CLR_EDGE: assert property (@(posedge clk) disable iff (!armed)
                !clr_n |=> count == '0); // R2
        end
    endgenerate

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !load_n) |=> (!clr_n || count == $past(preset))); // R3

    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && en_p && en_t) |=> (!clr_n || count == $past(count) + 1'b1)); // R4

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && !(en_p && en_t)) |=> (!clr_n || count == $past(count))); // R5

    AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!armed)
        carry == (en_t && (&count))); // R7

endmodule

bind cnt_chain cnt_chain_chk #(.CW(CW), .ASYNC_CLR(ASYNC_CLR)) u_chk (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(preset),
    .en_p(en_p), .en_t(en_t), .count(count), .carry(carry)
);

// File: tb/sim_cnt_chain.sv
`timescale 1ns/1ps
module sim_cnt_chain;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load_n = 1'b1;
    logic [7:0] preset = '0;
    logic       en_p = 1'b0;
    logic       en_t = 1'b0;
    logic [7:0] cnt_a, cnt_s;
    logic       cy_a, cy_s;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cnt_chain #(.SLICES(2), .ASYNC_CLR(1'b1)) u0 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(preset),
        .en_p(en_p), .en_t(en_t), .count(cnt_a), .carry(cy_a));

    cnt_chain #(.SLICES(2), .ASYNC_CLR(1'b0)) u1 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(preset),
        .en_p(en_p), .en_t(en_t), .count(cnt_s), .carry(cy_s));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic set(input logic c, input logic l, input logic p, input logic t, input logic [7:0] d);
        clr_n = c; load_n = l; en_p = p; en_t = t; preset = d;
    endtask

    task automatic both(input string req, input logic [7:0] exp);
        chk({req, " async"}, cnt_a, exp);
        chk({req, " sync"},  cnt_s, exp);
    endtask

    task automatic t_reset();
        set(0, 1, 0, 0, 8'h00);
        step();
        both("R1 R2 reset", 8'h00);
    endtask

    task automatic t_load();
        set(1, 0, 0, 0, 8'hA5);
        step();
        both("R3 load", 8'hA5);
    endtask

    task automatic t_count();
        set(1, 1, 1, 1, 8'h00);
        step(); step(); step();
        both("R4 count", 8'hA8);
    endtask

    task automatic t_hold();
        set(1, 1, 0, 1, 8'h00);
        step(); step();
        both("R5 hold en_p low", 8'hA8);
    endtask

    task automatic t_carry();
        set(1, 0, 0, 0, 8'hFF);
        step();
        set(1, 1, 0, 1, 8'h00);
        #1;
        chk("R7 carry with en_p low", {7'd0, cy_a}, 8'h01);
        set(1, 1, 1, 0, 8'h00);
        #1;
        chk("R7 carry with en_t low", {7'd0, cy_a}, 8'h00);
        step();
        both("R10 en_t low stops chain", 8'hFF);
    endtask

    task automatic t_wrap();
        set(1, 1, 1, 1, 8'h00);
        step();
        both("R6 wrap", 8'h00);
        chk("R7 carry after wrap", {7'd0, cy_s}, 8'h00);
    endtask

    task automatic t_cascade();
        set(1, 0, 0, 0, 8'h0F);
        step();
        set(1, 1, 1, 1, 8'h00);
        step();
        both("R9 cascade rollover", 8'h10);
    endtask

    task automatic t_load_over_count();
        set(1, 0, 1, 1, 8'h3C);
        step();
        both("R3 load beats count", 8'h3C);
    endtask

    task automatic t_clear_over_load();
        set(0, 0, 1, 1, 8'h77);
        step();
        both("R8 clear beats load", 8'h00);
    endtask

    task automatic t_midcycle_clear();
        set(1, 0, 0, 0, 8'h55);
        step();
        set(1, 1, 0, 0, 8'h00);
        step();
        clr_n = 1'b0;
        #3;
        chk("R1 async clear immediate", cnt_a, 8'h00);
        chk("R2 sync clear waits", cnt_s, 8'h55);
        step();
        chk("R2 sync clear at edge", cnt_s, 8'h00);
        set(1, 1, 0, 0, 8'h00);
        step();
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_count();
        t_hold();
        t_carry();
        t_wrap();
        t_cascade();
        t_load_over_count();
        t_clear_over_load();
        t_midcycle_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule